// File: doc/BRIEF.md
# Link Power Status Controller

This block sits on the PHY side of the PHY-to-link interface. It watches a power-status level driven by the link-layer controller and measures how long that level stays low. A brief dip is treated as noise and ignored. A dip of moderate length ends with a single reset pulse to the interface when the level returns. A long absence disables the interface until the level comes back. The repeater path is not affected by any of this.

While the interface is disabled, an arriving link-on packet starts a wake-up square wave of about 6.114 MHz on a dedicated output. The link layer uses this wave to power itself up. The wave stops when the status level returns or a bus reset occurs, but not while an interrupt that needs the link is still pending. The block also asks the PHY to enter its low-power mode when the interface is disabled and every port is inactive. It withdraws that request when the link returns or when a port event needs service.

All timing is in system-clock cycles. The two low-time thresholds and the wave's half period come from the clock-frequency parameter. A synchronous reset returns the block to an enabled interface with the wave off and no low-power request.

Top module: `link_pwr_ctrl`

## Requirements
- R1: After synchronous reset, `if_enable_o` is 1 and `if_reset_o`, `lkon_o` and `lowpwr_req_o` are 0.
- R2: `stat_in` passes through two synchronizing flops. If it is low for fewer than RST_CYC clock cycles (1.2 µs worth, rounded up), there is no reset pulse and the interface stays enabled.
- R3: If `stat_in` is low for at least RST_CYC but fewer than DIS_CYC cycles (25 µs worth), exactly one reset pulse follows its return high. The pulse is one cycle wide, and `if_enable_o` stays 1 throughout.
- R4: If `stat_in` is low for DIS_CYC cycles or more, `if_enable_o` falls about DIS_CYC cycles after the falling edge, and no reset pulse is issued for that interval.
- R5: While the interface is disabled, the synchronized return of `stat_in` to 1 re-enables it.
- R6: A link-on packet strobe starts the wake-up function only while the interface is disabled. A strobe while enabled is ignored, and `lkon_o` stays 0.
- R7: While the wake-up function is active, `lkon_o` is a square wave that starts low, with high and low phases of HALF cycles each. HALF is the clock frequency divided by twice 6.114 MHz, rounded to the nearest integer with a minimum of 1. `lkon_o` is 0 whenever the function is inactive.
- R8: The wake-up function stops when synchronized `stat_in` is high or `busrst_i` pulses, provided `irq_pend_i` is 0. While `irq_pend_i` is 1, neither condition stops it. A stop condition and a packet strobe in the same cycle leave the function off.
- R9: `lowpwr_req_o` is 1 only while the interface is disabled and every bit of `port_idle_i` is 1.
- R10: `lowpwr_req_o` falls when `stat_in` returns high. A `port_evt_i` strobe also drops it, and it stays low until some port leaves the idle state and all ports are idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| stat_in | input | 1 | Power-status level from the link layer (asynchronous) |
| lkon_pkt_i | input | 1 | One-cycle strobe: link-on packet received |
| busrst_i | input | 1 | One-cycle strobe: bus reset occurred |
| irq_pend_i | input | 1 | Interrupt condition that needs the link is still present |
| port_idle_i | input | NPORT | Per-port inactive flag (disconnected, disabled or suspended) |
| port_evt_i | input | 1 | One-cycle strobe: port event that needs service |
| if_reset_o | output | 1 | One-cycle reset pulse to the PHY-to-link interface |
| if_enable_o | output | 1 | PHY-to-link interface enabled |
| lkon_o | output | 1 | Wake-up square wave to the link layer |
| lowpwr_req_o | output | 1 | Request to enter low-power mode |

## Verification
The hardest states to reach are the ones that exist only after a long low interval: the wake-up wave, its interrupt-gated stop, and the low-power request with its port-event hold-off. All of them need the interface to be disabled first. The bench therefore holds the status input low past DIS_CYC once and then, without releasing it, runs the packet, interrupt, bus-reset and port-event sequences. It releases the status input only at the end, to check re-enable and the release of the wave and the request. The thresholds are tested exactly at their edges, one cycle on either side.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  // Cycles of a clock given in kHz that cover a span in ns, rounded up.
  function automatic int span_cycles(input int clk_khz, input int span_ns);
    longint prod;
    prod = longint'(clk_khz) * longint'(span_ns);
    return int'((prod + 64'd999999) / 64'd1000000);
  endfunction

  // Half period, in clock cycles, of a wave of out_hz; nearest integer, at least 1.
  function automatic int half_cycles(input int clk_khz, input int out_hz);
    longint clk_hz;
    longint h;
    clk_hz = longint'(clk_khz) * 64'd1000;
    h = (clk_hz + longint'(out_hz)) / (64'd2 * longint'(out_hz));
    if (h < 1) h = 1;
    return int'(h);
  endfunction

  // Counter width able to hold 0..maxval.
  function automatic int cnt_width(input int maxval);
    int w;
    w = 1;
    while ((1 << w) <= maxval) w++;
    return w;
  endfunction

endpackage

// File: rtl/lpc_sync.sv
module lpc_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/lpc_low_timer.sv
module lpc_low_timer #(
  parameter int RST_CYC = 120,
  parameter int DIS_CYC = 2500
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,        // synchronized status level
  output logic short_end_o,  // rise after a qualifying short low
  output logic long_hit_o    // low time is about to reach DIS_CYC
);
  import lpc_pkg::*;

  localparam int CW = cnt_width(DIS_CYC);
  localparam logic [CW-1:0] SHORT_MIN = CW'(RST_CYC);
  localparam logic [CW-1:0] LONG_MIN  = CW'(DIS_CYC);
  localparam logic [CW-1:0] LONG_PRE  = CW'(DIS_CYC - 1);

  logic [CW-1:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt <= '0;
    end else if (!lvl_i) begin
      if (lo_cnt != LONG_MIN) lo_cnt <= lo_cnt + 1'b1;
    end else begin
      lo_cnt <= '0;
    end
  end

  // A nonzero count with the level high marks the first high cycle.
  assign short_end_o = lvl_i && (lo_cnt >= SHORT_MIN) && (lo_cnt < LONG_MIN);
  assign long_hit_o  = !lvl_i && (lo_cnt == LONG_PRE);
endmodule

// File: rtl/lpc_linkon.sv
module lpc_linkon #(
  parameter int HALF = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic act_o,
  output logic wave_o
);
  import lpc_pkg::*;

  localparam int DW = cnt_width(HALF);
  localparam logic [DW-1:0] LAST = DW'(HALF - 1);

  logic          act;
  logic [DW-1:0] div;
  logic          wave;

  always_ff @(posedge clk) begin
    if (rst)        act <= 1'b0;
    else if (clr_i) act <= 1'b0;
    else if (set_i) act <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !act) begin
      div  <= '0;
      wave <= 1'b0;
    end else if (div == LAST) begin
      div  <= '0;
      wave <= !wave;
    end else begin
      div  <= div + 1'b1;
    end
  end

  assign act_o  = act;
  assign wave_o = wave & act;
endmodule

// File: rtl/lpc_lowpwr.sv
module lpc_lowpwr #(
  parameter int NPORT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             if_en_i,
  input  logic             lvl_i,
  input  logic [NPORT-1:0] idle_i,
  input  logic             evt_i,
  output logic             req_o
);
  logic all_idle;
  logic evt_hold;
  logic req;

  assign all_idle = &idle_i;

  // A serviced port event blocks re-entry until a port has become active.
  always_ff @(posedge clk) begin
    if (rst)                       evt_hold <= 1'b0;
    else if (if_en_i || !all_idle) evt_hold <= 1'b0;
    else if (evt_i)                evt_hold <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= !if_en_i && all_idle && !evt_hold && !evt_i && !lvl_i;
  end

  assign req_o = req;
endmodule

// File: rtl/link_pwr_ctrl.sv
module link_pwr_ctrl #(
  parameter int CLK_KHZ = 100000,
  parameter int NPORT   = 2,
  parameter int LKON_HZ = 6114000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stat_in,
  input  logic             lkon_pkt_i,
  input  logic             busrst_i,
  input  logic             irq_pend_i,
  input  logic [NPORT-1:0] port_idle_i,
  input  logic             port_evt_i,
  output logic             if_reset_o,
  output logic             if_enable_o,
  output logic             lkon_o,
  output logic             lowpwr_req_o
);
  import lpc_pkg::*;

  localparam int RST_CYC = span_cycles(CLK_KHZ, 1200);
  localparam int DIS_CYC = span_cycles(CLK_KHZ, 25000);
  localparam int HALF    = half_cycles(CLK_KHZ, LKON_HZ);

  logic lps_s;
  logic short_end;
  logic long_hit;
  logic lkon_set;
  logic lkon_clr;
  logic lkon_act;
  logic if_en;
  logic if_rst;

  lpc_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d_i(stat_in), .q_o(lps_s)
  );

  lpc_low_timer #(.RST_CYC(RST_CYC), .DIS_CYC(DIS_CYC)) u_timer (
    .clk(clk), .rst(rst), .lvl_i(lps_s),
    .short_end_o(short_end), .long_hit_o(long_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      if_en  <= 1'b1;
      if_rst <= 1'b0;
    end else begin
      if_rst <= short_end;
      if (long_hit)            if_en <= 1'b0;
      else if (lps_s && !if_en) if_en <= 1'b1;
    end
  end

  assign lkon_set = lkon_pkt_i && !if_en;
  assign lkon_clr = (lps_s || busrst_i) && !irq_pend_i;

  lpc_linkon #(.HALF(HALF)) u_lkon (
    .clk(clk), .rst(rst), .set_i(lkon_set), .clr_i(lkon_clr),
    .act_o(lkon_act), .wave_o(lkon_o)
  );

  lpc_lowpwr #(.NPORT(NPORT)) u_lp (
    .clk(clk), .rst(rst), .if_en_i(if_en), .lvl_i(lps_s),
    .idle_i(port_idle_i), .evt_i(port_evt_i), .req_o(lowpwr_req_o)
  );

  assign if_enable_o = if_en;
  assign if_reset_o  = if_rst;
endmodule

// File: rtl/lpc_checker.sv
module lpc_checker (
  input logic clk,
  input logic rst,
  input logic if_reset_o,
  input logic if_enable_o,
  input logic lowpwr_req_o,
  input logic port_evt_i,
  input logic busrst_i,
  input logic irq_pend_i,
  input logic lkon_act,
  input logic lps_s,
  input logic long_hit
);
  // R3: the interface reset is a single-cycle pulse
  assert_rst_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    if_reset_o |=> !if_reset_o);

  // R3: a reset pulse never coincides with a disabled interface
  assert_rst_while_enabled_R3: assert property (@(posedge clk) disable iff (rst)
    if_reset_o |-> if_enable_o);

  // R4: reaching the long threshold disables the interface
  assert_long_disables_R4: assert property (@(posedge clk) disable iff (rst)
    long_hit |=> !if_enable_o);

  // R5: a returned status level re-enables a disabled interface
  assert_reenable_R5: assert property (@(posedge clk) disable iff (rst)
    (lps_s && !if_enable_o) |=> if_enable_o);

  // R8: a pending interrupt keeps the wake-up function alive
  assert_irq_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (lkon_act && irq_pend_i) |=> lkon_act);

  // R8: a bus reset without a pending interrupt stops the wake-up function
  assert_busrst_stops_R8: assert property (@(posedge clk) disable iff (rst)
    (busrst_i && !irq_pend_i) |=> !lkon_act);

  // R9: low power is requested only with the interface disabled
  assert_lp_needs_disable_R9: assert property (@(posedge clk) disable iff (rst)
    lowpwr_req_o |-> !if_enable_o);

  // R10: a port event withdraws the low-power request
  assert_evt_wakes_R10: assert property (@(posedge clk) disable iff (rst)
    port_evt_i |=> !lowpwr_req_o);
endmodule

bind link_pwr_ctrl lpc_checker u_chk (
  .clk(clk), .rst(rst), .if_reset_o(if_reset_o), .if_enable_o(if_enable_o),
  .lowpwr_req_o(lowpwr_req_o), .port_evt_i(port_evt_i), .busrst_i(busrst_i),
  .irq_pend_i(irq_pend_i), .lkon_act(lkon_act), .lps_s(lps_s), .long_hit(long_hit)
);

// File: tb/tb_link_pwr_ctrl.sv
module tb_link_pwr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int KHZ   = 20000;
  localparam int NP    = 2;
  // Thresholds restated: 1.2 us and 25 us at 20 MHz, wave half period at 6.114 MHz.
  localparam int T_SHORT = (KHZ * 12 + 9999) / 10000;            // 24
  localparam int T_LONG  = (KHZ * 25 + 999) / 1000;              // 500
  localparam int T_HALF  = (KHZ * 2000 + 12228000) / 24456000;   // 2

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stat_in = 1'b1;
  logic lkon_pkt_i = 1'b0;
  logic busrst_i = 1'b0;
  logic irq_pend_i = 1'b0;
  logic [NP-1:0] port_idle_i = '0;
  logic port_evt_i = 1'b0;
  logic if_reset_o, if_enable_o, lkon_o, lowpwr_req_o;

  int checks = 0;
  int errors = 0;
  int pulse_hi = 0;
  int pulse_rise = 0;
  int dis_seen = 0;
  int wave_edges = 0;
  logic prev_rst = 1'b0;
  logic prev_wave = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = !clk;

  link_pwr_ctrl #(.CLK_KHZ(KHZ), .NPORT(NP)) dut (
    .clk(clk), .rst(rst), .stat_in(stat_in), .lkon_pkt_i(lkon_pkt_i),
    .busrst_i(busrst_i), .irq_pend_i(irq_pend_i), .port_idle_i(port_idle_i),
    .port_evt_i(port_evt_i), .if_reset_o(if_reset_o), .if_enable_o(if_enable_o),
    .lkon_o(lkon_o), .lowpwr_req_o(lowpwr_req_o)
  );

  // Output monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (if_reset_o) pulse_hi++;
      if (if_reset_o && !prev_rst) pulse_rise++;
      if (!if_enable_o) dis_seen++;
      if (lkon_o != prev_wave) wave_edges++;
    end
    prev_rst  = if_reset_o;
    prev_wave = lkon_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Measure high and low phase lengths of the wake-up wave.
  task automatic wave_phases(input string req);
    int hi, lo, waitc;
    waitc = 0;
    while (!lkon_o && waitc < 40) begin @(negedge clk); waitc++; end
    hi = 0;
    while (lkon_o && hi < 40) begin hi++; @(negedge clk); end
    lo = 0;
    while (!lkon_o && lo < 40) begin lo++; @(negedge clk); end
    check(hi == T_HALF, req, hi, T_HALF);
    check(lo == T_HALF, req, lo, T_HALF);
  endtask

  // Table: low length in cycles, expected pulses, expect a disable.
  typedef struct packed { int len; int pulses; int dis; } row_t;
  localparam row_t ROWS [6] = '{
    '{1,           0, 0},   // R2 glitch
    '{T_SHORT - 1, 0, 0},   // R2 just under the short threshold
    '{T_SHORT,     1, 0},   // R3 at the short threshold
    '{T_LONG - 1,  1, 0},   // R3 just under the long threshold
    '{T_LONG,      0, 1},   // R4 at the long threshold
    '{T_LONG + 60, 0, 1}    // R4 well past it
  };

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    int p0, h0, d0, e0;
    cyc(3);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(if_enable_o == 1'b1, "R1 enable", if_enable_o, 1);
    check(if_reset_o == 1'b0, "R1 reset pulse", if_reset_o, 0);
    check(lkon_o == 1'b0, "R1 link-on", lkon_o, 0);
    check(lowpwr_req_o == 1'b0, "R1 low power", lowpwr_req_o, 0);

    // R6: packet while enabled is ignored
    strobe(lkon_pkt_i);
    e0 = wave_edges;
    cyc(20);
    check(wave_edges == e0 && lkon_o == 1'b0, "R6 ignored while enabled", wave_edges - e0, 0);

    for (int r = 0; r < 6; r++) begin
      p0 = pulse_rise; h0 = pulse_hi; d0 = dis_seen;
      @(negedge clk); stat_in = 1'b0;
      cyc(ROWS[r].len);
      stat_in = 1'b1;
      cyc(12);
      check(pulse_rise - p0 == ROWS[r].pulses, "R2/R3/R4 pulse count", pulse_rise - p0, ROWS[r].pulses);
      check(pulse_hi - h0 == ROWS[r].pulses, "R3 pulse width", pulse_hi - h0, ROWS[r].pulses);
      check((dis_seen != d0) == (ROWS[r].dis != 0), "R3/R4 disable seen", dis_seen - d0, ROWS[r].dis);
      check(if_enable_o == 1'b1, "R5 enabled after return", if_enable_o, 1);
    end

    // Directed: disable and stay disabled.
    port_idle_i = 2'b01;
    @(negedge clk); stat_in = 1'b0;
    cyc(T_LONG - 2);
    check(if_enable_o == 1'b1, "R4 before threshold", if_enable_o, 1);
    cyc(6);
    check(if_enable_o == 1'b0, "R4 after threshold", if_enable_o, 0);
    cyc(3);
    check(lowpwr_req_o == 1'b0, "R9 one port active", lowpwr_req_o, 0);
    port_idle_i = 2'b11;
    cyc(3);
    check(lowpwr_req_o == 1'b1, "R9 all idle", lowpwr_req_o, 1);

    // R10 port event hold-off
    strobe(port_evt_i);
    cyc(10);
    check(lowpwr_req_o == 1'b0, "R10 after port event", lowpwr_req_o, 0);
    port_idle_i = 2'b10;
    cyc(2);
    port_idle_i = 2'b11;
    cyc(3);
    check(lowpwr_req_o == 1'b1, "R10 re-entry after activity", lowpwr_req_o, 1);

    // R8: stop and start in the same cycle stays off
    @(negedge clk); lkon_pkt_i = 1'b1; busrst_i = 1'b1;
    @(negedge clk); lkon_pkt_i = 1'b0; busrst_i = 1'b0;
    e0 = wave_edges;
    cyc(12);
    check(wave_edges == e0, "R8 stop wins over start", wave_edges - e0, 0);

    // R6/R7: packet while disabled starts the wave
    strobe(lkon_pkt_i);
    wave_phases("R7 half period");

    // R8: interrupt pending blocks the bus-reset stop
    irq_pend_i = 1'b1;
    strobe(busrst_i);
    e0 = wave_edges;
    cyc(4 * T_HALF + 2);
    check(wave_edges - e0 >= 3, "R8 irq keeps wave", wave_edges - e0, 4);
    irq_pend_i = 1'b0;
    strobe(busrst_i);
    cyc(2);
    e0 = wave_edges;
    cyc(12);
    check(wave_edges == e0 && lkon_o == 1'b0, "R8 bus reset stops wave", wave_edges - e0, 0);

    // R8/R5/R10: restart, then status returns
    strobe(lkon_pkt_i);
    cyc(4 * T_HALF);
    p0 = pulse_rise;
    @(negedge clk); stat_in = 1'b1;
    cyc(6);
    e0 = wave_edges;
    cyc(10);
    check(wave_edges == e0 && lkon_o == 1'b0, "R8 status return stops wave", wave_edges - e0, 0);
    check(if_enable_o == 1'b1, "R5 re-enable", if_enable_o, 1);
    check(lowpwr_req_o == 1'b0, "R10 status return", lowpwr_req_o, 0);
    check(pulse_rise == p0, "R4 no pulse after long low", pulse_rise - p0, 0);

    finish_up();
  end
endmodule